// File: doc/BRIEF.md
# Floating-Point NaN Classifier and Quieter

This block inspects one floating-point operand, in single (binary32) or double (binary64) format, and reports whether it is a NaN and, if so, whether it is quiet or signalling. It also produces a quieted copy of the operand, where a signalling NaN is turned into a quiet one and any other value passes through unchanged. Alongside these results it produces a default NaN word in the selected format for one of five styles.

Three run-time controls set how NaNs are read. A polarity control decides whether a set top fraction bit means quiet (normal) or signalling (inverted). A mode control makes the block treat every NaN as quiet. The format select chooses the field layout. A binary32 operand sits in the low 32 bits of the operand port. Binary32 results come back zero-extended in the low 32 bits of the 64-bit outputs.

With the default parameters all results are held in an output register and appear one clock after the input. A parameter can remove this register.

Top module: `fp_nan_unit`

## Requirements
- R1: `is_nan` is 1 exactly when the exponent field is all ones and the fraction field is nonzero. With `fmt_dbl`=0 the fields are `operand[30:23]` and `operand[22:0]`, and `operand[63:32]` is ignored. With `fmt_dbl`=1 the fields are `operand[62:52]` and `operand[51:0]`.
- R2: With `quiet_inv`=0 and `nosig_mode`=0, a NaN whose top fraction bit is 1 is quiet and a NaN whose top fraction bit is 0 is signalling.
- R3: With `quiet_inv`=1 and `nosig_mode`=0, a NaN whose top fraction bit is 1 is signalling. A NaN whose top fraction bit is 0 is quiet, provided the lower fraction bits are nonzero.
- R4: With `nosig_mode`=1, `is_sig` is always 0 and `is_quiet` equals `is_nan`.
- R5: `is_quiet` and `is_sig` are never both 1. Neither is 1 for a non-NaN.
- R6: With normal polarity, `quieted` of a signalling NaN is the operand with the top fraction bit set.
- R7: With inverted polarity, `quieted` of a signalling NaN is the operand with the top fraction bit cleared and the bit just below it set.
- R8: For any operand that is not a signalling NaN, including infinities, quiet NaNs and every value in `nosig_mode`, `quieted` equals the operand, zero-extended for binary32.
- R9: `dflt_nan` always has the exponent field all ones. Its sign and fraction depend on `dnan_style`:
  - 0: positive, top fraction bit only.
  - 1: negative, top fraction bit only.
  - 2: positive, all fraction bits set.
  - 3: positive, all fraction bits except the top one.
  - 4: positive, only the bit below the top.
  - 5 to 7: same as style 0.
- R10: With `fmt_dbl`=0, bits 63:32 of both `quieted` and `dflt_nan` are 0.
- R11: `out_valid` is 1 in the cycle after a cycle with `in_valid`=1, and 0 otherwise. The other outputs show the results for the inputs of the previous cycle. A synchronous `rst` clears `out_valid` and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input qualifier |
| operand | input | 64 | Operand; binary32 uses bits 31:0 |
| fmt_dbl | input | 1 | 1 = binary64, 0 = binary32 |
| quiet_inv | input | 1 | 1 = set top fraction bit means signalling |
| nosig_mode | input | 1 | 1 = every NaN counts as quiet |
| dnan_style | input | 3 | Default NaN style code (R9) |
| out_valid | output | 1 | Results valid |
| is_nan | output | 1 | Operand is a NaN |
| is_quiet | output | 1 | Operand is a quiet NaN |
| is_sig | output | 1 | Operand is a signalling NaN |
| quieted | output | 64 | Operand with a signalling NaN made quiet |
| dflt_nan | output | 64 | Default NaN for the style and format |

## Verification
The hardest cases are the boundary patterns under inverted polarity:
- a NaN whose only set fraction bit is the top bit (signalling);
- a NaN whose only set bit is the lowest fraction bit (quiet);
- infinity, whose fraction is zero and which must not count as quiet even though its top fraction bit is 0.

Uniformly random operands almost never hit the all-ones exponent. The stimulus therefore forces the exponent field to all ones in half of the random vectors, and also thins the fraction so that single-bit fractions appear. Directed vectors cover each of these patterns in both formats, with junk in the upper word during binary32 operation.

// File: rtl/fp_nan_pkg.sv
`timescale 1ns/1ps
package fp_nan_pkg;

  typedef enum logic [2:0] {
    DN_MSB_POS = 3'd0,
    DN_MSB_NEG = 3'd1,
    DN_ALL_POS = 3'd2,
    DN_LOW_POS = 3'd3,
    DN_SUB_POS = 3'd4
  } dnan_style_e;

  typedef struct packed {
    logic nan;
    logic quiet;
    logic sig;
  } nan_flags_t;

endpackage

// File: rtl/nan_lane.sv
`timescale 1ns/1ps
// Classifies and quiets one operand of a fixed field layout.
module nan_lane
  import fp_nan_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] word_i,
  input  logic         quiet_inv_i,
  input  logic         nosig_i,
  output nan_flags_t   flags_o,
  output logic [W-1:0] quieted_o
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic exp_ones;
  logic frac_nz;
  logic top_bit;
  logic sig_raw;

  assign exp_f    = word_i[W-2 -: EXP_W];
  assign frac_f   = word_i[FRAC_W-1:0];
  assign exp_ones = &exp_f;
  assign frac_nz  = |frac_f;
  assign top_bit  = frac_f[FRAC_W-1];

  always_comb begin
    flags_o.nan   = exp_ones & frac_nz;
    // A NaN with top bit 0 always has a nonzero lower fraction.
    sig_raw       = flags_o.nan & (top_bit == quiet_inv_i);
    flags_o.sig   = sig_raw & ~nosig_i;
    flags_o.quiet = flags_o.nan & ~flags_o.sig;
    quieted_o     = word_i;
    if (flags_o.sig) begin
      if (quiet_inv_i) begin
        quieted_o[FRAC_W-1] = 1'b0;
        quieted_o[FRAC_W-2] = 1'b1;
      end else begin
        quieted_o[FRAC_W-1] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/nan_default_gen.sv
`timescale 1ns/1ps
// Builds the default NaN word for one field layout.
module nan_default_gen
  import fp_nan_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [2:0]   style_i,
  output logic [W-1:0] nan_o
);

  logic              sign_b;
  logic [FRAC_W-1:0] frac_b;

  always_comb begin
    sign_b = 1'b0;
    frac_b = '0;
    case (style_i)
      DN_MSB_NEG: begin
        sign_b             = 1'b1;
        frac_b[FRAC_W-1]   = 1'b1;
      end
      DN_ALL_POS: frac_b = '1;
      DN_LOW_POS: begin
        frac_b             = '1;
        frac_b[FRAC_W-1]   = 1'b0;
      end
      DN_SUB_POS: frac_b[FRAC_W-2] = 1'b1;
      default:    frac_b[FRAC_W-1] = 1'b1;
    endcase
    nan_o = {sign_b, {EXP_W{1'b1}}, frac_b};
  end

endmodule

// File: rtl/nan_out_stage.sv
`timescale 1ns/1ps
// Optional output register for all results.
module nan_out_stage
  import fp_nan_pkg::*;
#(
  parameter int W       = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_i,
  input  nan_flags_t   flags_i,
  input  logic [W-1:0] quiet_i,
  input  logic [W-1:0] dflt_i,
  output logic         valid_o,
  output nan_flags_t   flags_o,
  output logic [W-1:0] quiet_o,
  output logic [W-1:0] dflt_o
);

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          valid_o <= 1'b0;
          flags_o <= '0;
          quiet_o <= '0;
          dflt_o  <= '0;
        end else begin
          valid_o <= valid_i;
          flags_o <= flags_i;
          quiet_o <= quiet_i;
          dflt_o  <= dflt_i;
        end
      end
    end else begin : g_wire
      logic unused_clkrst;
      assign unused_clkrst = clk ^ rst;
      assign valid_o = valid_i;
      assign flags_o = flags_i;
      assign quiet_o = quiet_i;
      assign dflt_o  = dflt_i;
    end
  endgenerate

endmodule

// File: rtl/fp_nan_unit.sv
`timescale 1ns/1ps
// NaN classifier, quieter and default NaN source for binary32/binary64.
module fp_nan_unit
  import fp_nan_pkg::*;
#(
  parameter int SP_EXP_W  = 8,
  parameter int SP_FRAC_W = 23,
  parameter int DP_EXP_W  = 11,
  parameter int DP_FRAC_W = 52,
  parameter bit OUT_REG   = 1'b1,
  localparam int SP_W     = 1 + SP_EXP_W + SP_FRAC_W,
  localparam int DP_W     = 1 + DP_EXP_W + DP_FRAC_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [DP_W-1:0] operand,
  input  logic            fmt_dbl,
  input  logic            quiet_inv,
  input  logic            nosig_mode,
  input  logic [2:0]      dnan_style,
  output logic            out_valid,
  output logic            is_nan,
  output logic            is_quiet,
  output logic            is_sig,
  output logic [DP_W-1:0] quieted,
  output logic [DP_W-1:0] dflt_nan
);

  localparam int PAD_W = DP_W - SP_W;

  nan_flags_t      sp_flags, dp_flags, sel_flags, reg_flags;
  logic [SP_W-1:0] sp_quiet, sp_dflt;
  logic [DP_W-1:0] dp_quiet, dp_dflt, sel_quiet, sel_dflt;
  logic            sel_top, sel_sub;

  nan_lane #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_sp_lane (
    .word_i(operand[SP_W-1:0]), .quiet_inv_i(quiet_inv), .nosig_i(nosig_mode),
    .flags_o(sp_flags), .quieted_o(sp_quiet)
  );

  nan_lane #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_dp_lane (
    .word_i(operand), .quiet_inv_i(quiet_inv), .nosig_i(nosig_mode),
    .flags_o(dp_flags), .quieted_o(dp_quiet)
  );

  nan_default_gen #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_sp_dflt (
    .style_i(dnan_style), .nan_o(sp_dflt)
  );

  nan_default_gen #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_dp_dflt (
    .style_i(dnan_style), .nan_o(dp_dflt)
  );

  assign sel_flags = fmt_dbl ? dp_flags : sp_flags;
  assign sel_quiet = fmt_dbl ? dp_quiet : {{PAD_W{1'b0}}, sp_quiet};
  assign sel_dflt  = fmt_dbl ? dp_dflt  : {{PAD_W{1'b0}}, sp_dflt};
  assign sel_top   = fmt_dbl ? sel_quiet[DP_FRAC_W-1] : sel_quiet[SP_FRAC_W-1];
  assign sel_sub   = fmt_dbl ? sel_quiet[DP_FRAC_W-2] : sel_quiet[SP_FRAC_W-2];

  nan_out_stage #(.W(DP_W), .OUT_REG(OUT_REG)) u_out (
    .clk(clk), .rst(rst), .valid_i(in_valid), .flags_i(sel_flags),
    .quiet_i(sel_quiet), .dflt_i(sel_dflt), .valid_o(out_valid),
    .flags_o(reg_flags), .quiet_o(quieted), .dflt_o(dflt_nan)
  );

  assign is_nan   = reg_flags.nan;
  assign is_quiet = reg_flags.quiet;
  assign is_sig   = reg_flags.sig;

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sel_flags.quiet && sel_flags.sig)); // R5
  AST_OUT_FLAG_NAN: assert property (@(posedge clk) disable iff (rst)
    (is_quiet || is_sig) |-> is_nan); // R5
  AST_NOSIG_NONE: assert property (@(posedge clk) disable iff (rst)
    nosig_mode |-> !sel_flags.sig); // R4
  AST_QUIET_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (sel_flags.sig && !quiet_inv) |-> sel_top); // R6
  AST_QUIET_INVERT: assert property (@(posedge clk) disable iff (rst)
    (sel_flags.sig && quiet_inv) |-> (!sel_top && sel_sub)); // R7
  AST_SP_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    !fmt_dbl |-> (sel_quiet[DP_W-1:SP_W] == '0 && sel_dflt[DP_W-1:SP_W] == '0)); // R10

  generate
    if (OUT_REG) begin : g_vchk
      AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R11
      AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R11
    end
  endgenerate

endmodule

// File: tb/fp_nan_unit_tb.sv
`timescale 1ns/1ps
module fp_nan_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] operand = '0;
  logic        fmt_dbl = 1'b0;
  logic        quiet_inv = 1'b0;
  logic        nosig_mode = 1'b0;
  logic [2:0]  dnan_style = '0;
  logic        out_valid, is_nan, is_quiet, is_sig;
  logic [63:0] quieted, dflt_nan;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  fp_nan_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
    .fmt_dbl(fmt_dbl), .quiet_inv(quiet_inv), .nosig_mode(nosig_mode),
    .dnan_style(dnan_style), .out_valid(out_valid), .is_nan(is_nan),
    .is_quiet(is_quiet), .is_sig(is_sig), .quieted(quieted), .dflt_nan(dflt_nan)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  function automatic void model(input logic [63:0] op, input bit dbl, input bit inv,
                                input bit nosig, input logic [2:0] st,
                                output bit en, output bit eq, output bit es,
                                output logic [63:0] eqv, output logic [63:0] edn);
    int ew = dbl ? 11 : 8;
    int fw = dbl ? 52 : 23;
    logic [63:0] w, ex, fr, top, sub, fr_d;
    w   = dbl ? op : {32'b0, op[31:0]};
    ex  = (w >> fw) & ((64'd1 << ew) - 1);
    fr  = w & ((64'd1 << fw) - 1);
    top = 64'd1 << (fw - 1);
    sub = 64'd1 << (fw - 2);
    en  = (ex == ((64'd1 << ew) - 1)) && (fr != 0);
    es  = en && !nosig && (inv ? ((fr & top) != 0) : ((fr & top) == 0));
    eq  = en && !es;
    eqv = w;
    if (es) eqv = inv ? ((w & ~top) | sub) : (w | top);
    case (st)
      3'd2: fr_d = (64'd1 << fw) - 1;
      3'd3: fr_d = top - 1;
      3'd4: fr_d = sub;
      default: fr_d = top;
    endcase
    edn = (((64'd1 << ew) - 1) << fw) | fr_d;
    if (st == 3'd1) edn = edn | (64'd1 << (ew + fw));
  endfunction

  task automatic run_vec(input logic [63:0] op, input bit dbl, input bit inv,
                         input bit nosig, input logic [2:0] st);
    bit en, eq, es;
    logic [63:0] eqv, edn;
    string ftag, qtag;
    @(negedge clk);
    operand = op; fmt_dbl = dbl; quiet_inv = inv; nosig_mode = nosig;
    dnan_style = st; in_valid = 1'b1;
    @(negedge clk);
    model(op, dbl, inv, nosig, st, en, eq, es, eqv, edn);
    ftag = nosig ? "R4" : (inv ? "R3" : "R2");
    qtag = es ? (inv ? "R7" : "R6") : "R8";
    chk("R11 out_valid", {63'b0, out_valid}, 64'd1);
    chk("R1 is_nan", {63'b0, is_nan}, {63'b0, en});
    chk({ftag, " is_quiet"}, {63'b0, is_quiet}, {63'b0, eq});
    chk({ftag, " is_sig"}, {63'b0, is_sig}, {63'b0, es});
    chk("R5 exclusive", {63'b0, is_quiet & is_sig}, 64'd0);
    chk({qtag, " quieted"}, quieted, eqv);
    chk("R9 dflt_nan", dflt_nan, edn);
    if (!dbl) chk("R10 upper zero", {32'b0, quieted[63:32] | dflt_nan[63:32]}, 64'd0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [63:0] rop;
    int unsigned seed0;
    seed0 = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk("R11 reset out_valid", {63'b0, out_valid}, 64'd0);
    chk("R11 reset is_nan", {63'b0, is_nan}, 64'd0);
    rst = 1'b0;
    // R1 infinities and zero are not NaN
    run_vec(64'h0000_0000_7F80_0000, 0, 0, 0, 0);
    run_vec(64'h7FF0_0000_0000_0000, 1, 1, 0, 1);
    run_vec(64'h0, 1, 0, 0, 2);
    // R2 normal polarity
    run_vec(64'h0000_0000_7F80_0001, 0, 0, 0, 3);
    run_vec(64'h0000_0000_FFC0_0000, 0, 0, 0, 4);
    run_vec(64'hFFF0_0000_0000_0001, 1, 0, 0, 0);
    // R3 and R7 inverted polarity boundaries
    run_vec(64'h0000_0000_7FC0_0000, 0, 1, 0, 0);
    run_vec(64'h0000_0000_7F80_0001, 0, 1, 0, 1);
    run_vec(64'h7FF0_0000_0000_0001, 1, 1, 0, 2);
    run_vec(64'h7FF8_0000_0000_0000, 1, 1, 0, 3);
    run_vec(64'h7FFF_FFFF_FFFF_FFFF, 1, 1, 0, 4);
    // R4 no-signalling mode
    run_vec(64'h0000_0000_7F80_0001, 0, 0, 1, 0);
    run_vec(64'h7FF8_0000_0000_0000, 1, 1, 1, 1);
    // R10 junk in upper word for binary32
    run_vec(64'hDEAD_BEEF_7F80_0005, 0, 0, 0, 2);
    run_vec(64'hFFFF_FFFF_3F80_0000, 0, 1, 0, 3);
    // R9 all styles in both formats, including codes 5..7
    for (int s = 0; s < 8; s++) begin
      run_vec(64'h3FF0_0000_0000_0000, 1, 0, 0, 3'(s));
      run_vec(64'h0000_0000_3F80_0000, 0, 0, 0, 3'(s));
    end
    // R11 valid drops one cycle after in_valid falls
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    chk("R11 valid low", {63'b0, out_valid}, 64'd0);
    // random, biased toward NaNs and sparse fractions
    for (int i = 0; i < 600; i++) begin
      bit dbl;
      dbl = $urandom() & 1;
      rop = {$urandom(), $urandom()};
      if ($urandom() & 1) begin
        if (dbl) rop[62:52] = '1; else rop[30:23] = '1;
      end
      if (($urandom() % 4) == 0) begin
        if (dbl) rop[51:0] = 52'd1 << ($urandom() % 52);
        else rop[22:0] = 23'd1 << ($urandom() % 23);
      end
      run_vec(rop, dbl, 1'($urandom()), 1'(($urandom() % 4) == 0), 3'($urandom()));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule